// File: doc/BRIEF.md
# Programmable Read-Only Memory with Control-Pin Mode Decoding

This block is a synthesizable behavioural model of a byte-wide programmable read-only memory together with the logic that turns its control pins into an operating mode. It has an active-low chip enable and an active-low output enable. A flag marks that the programming supply is present on the pin that is shared with the output enable. A second flag marks a high voltage on address line 9. There is also an address bus and a data bus. The data bus is split into an input, an output and a drive enable, so each mode's high-impedance behaviour can be seen directly. Analog levels appear only as these digital flags.

The decoder picks one of six behaviours: read (which also serves as program verify), output disable, standby, program, program inhibit and identification. A program cycle can only clear bits: the stored word becomes the AND of its old value and the data input. The array starts with every bit set. A bulk-erase input sets every word back to all ones by sweeping the array one word per cycle. A parameter ties this input off for one-time-programmable builds. The array is a simple dual-port memory with a registered read, so an FPGA can map it onto block RAM. The output register adds one more cycle, so an operation's result appears two clock edges after it is presented.

Top module: `prom_core`

## Requirements
- R1: While `rst` is high, `data_oe` is low from the next clock edge on.
- R2: With `ce_n`=0, `oe_n`=0, `vpp_hi`=0 and `a9_hv`=0, the word stored at `addr` is driven on `data_out` with `data_oe`=1 two clock edges after the inputs are sampled. This includes writes made by the immediately preceding cycles.
- R3: With `ce_n`=0, `vpp_hi`=0 and `oe_n`=1, `data_oe` is 0 and the array is unchanged.
- R4: With `ce_n`=1 and `vpp_hi`=0, `data_oe` is 0 whatever `oe_n`, `a9_hv` and `addr` are.
- R5: With `ce_n`=0 and `vpp_hi`=1, the addressed word becomes the old word AND `data_in`, and `data_oe` is 0. `oe_n` and `a9_hv` have no effect.
- R6: With `ce_n`=1 and `vpp_hi`=1, nothing is written and `data_oe` is 0.
- R7: With `ce_n`=0, `oe_n`=0, `vpp_hi`=0 and `a9_hv`=1, the output is 0x97 when `addr[0]`=0 and 0x85 when `addr[0]`=1, whatever the array holds.
- R8: Before any programming, every word reads 0xFF.
- R9: Programming never sets a bit. Repeated or back-to-back program cycles to one address accumulate as the AND of all their data, and a program cycle with 0xFF leaves the word unchanged.
- R10: When ERASABLE=1, a cycle with `bulk_erase`=1 starts a sweep. The sweep covers the next DEPTH cycles, one word per cycle. Operations sampled during the sweep are treated as standby: no output and no writes. Afterwards every word reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the pipeline |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low (shared pin with programming supply) |
| vpp_hi | input | 1 | Programming supply present on the shared pin |
| a9_hv | input | 1 | High voltage present on address line 9 |
| addr | input | AW | Word address, AW = log2(DEPTH) |
| data_in | input | DW | Data presented for programming |
| bulk_erase | input | 1 | Start of a whole-array erase (ignored when ERASABLE=0) |
| data_out | output | DW | Data driven onto the bus |
| data_oe | output | 1 | Bus drive enable; 0 means high impedance |

## Verification
The bench builds the block with DEPTH=64 and ERASABLE=1. With only 64 words, several thousand random operations revisit each address many times. This drives many words down to zero through accumulated AND writes and produces many back-to-back program/read pairs on the same address, which stress the write forwarding. The small depth also keeps a full erase sweep to 64 cycles. The bench can then issue program and read cycles in every slot of the sweep and read the whole array back afterwards.

// File: rtl/prom_pkg.sv
package prom_pkg;

  typedef enum logic [2:0] {
    MD_STANDBY   = 3'd0,
    MD_INHIBIT   = 3'd1,
    MD_PROGRAM   = 3'd2,
    MD_DISABLE   = 3'd3,
    MD_READ      = 3'd4,
    MD_SIGNATURE = 3'd5
  } prom_mode_e;

  localparam logic [7:0] MFG_ID_DEFAULT = 8'h97;
  localparam logic [7:0] DEV_ID_DEFAULT = 8'h85;

endpackage

// File: rtl/prom_mode_dec.sv
module prom_mode_dec
  import prom_pkg::*;
(
  input  logic       ce_n,
  input  logic       oe_n,
  input  logic       vpp_hi,
  input  logic       a9_hv,
  output prom_mode_e mode
);

  // The supply flag outranks the output enable: both share one pin.
  always_comb begin
    if (ce_n) begin
      mode = vpp_hi ? MD_INHIBIT : MD_STANDBY;
    end else if (vpp_hi) begin
      mode = MD_PROGRAM;
    end else if (oe_n) begin
      mode = MD_DISABLE;
    end else if (a9_hv) begin
      mode = MD_SIGNATURE;
    end else begin
      mode = MD_READ;
    end
  end

endmodule

// File: rtl/prom_array.sv
module prom_array #(
  parameter int DEPTH = 2048,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  // Blank part: every cell starts at logic one.
  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = '1;
    end
  end

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  // Registered read; a write at the same edge is not seen (read-first).
  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/prom_eraser.sv
module prom_eraser #(
  parameter int DEPTH    = 2048,
  parameter bit ERASABLE = 1'b1,
  localparam int AW      = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          busy,
  output logic [AW-1:0] addr
);

  generate
    if (ERASABLE) begin : g_sweep
      localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
      logic          busy_q;
      logic [AW-1:0] cnt_q;

      always_ff @(posedge clk) begin
        if (rst) begin
          busy_q <= 1'b0;
          cnt_q  <= '0;
        end else if (!busy_q) begin
          if (start) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
          end
        end else begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST) begin
            busy_q <= 1'b0;
          end
        end
      end

      assign busy = busy_q;
      assign addr = cnt_q;
    end else begin : g_fixed
      assign busy = 1'b0;
      assign addr = '0;
    end
  endgenerate

endmodule

// File: rtl/prom_core.sv
module prom_core
  import prom_pkg::*;
#(
  parameter int             DEPTH    = 2048,
  parameter int             DW       = 8,
  parameter bit             ERASABLE = 1'b1,
  parameter logic [DW-1:0]  MFG_ID   = DW'(MFG_ID_DEFAULT),
  parameter logic [DW-1:0]  DEV_ID   = DW'(DEV_ID_DEFAULT),
  localparam int            AW       = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          vpp_hi,
  input  logic          a9_hv,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data_in,
  input  logic          bulk_erase,
  output logic [DW-1:0] data_out,
  output logic          data_oe
);

  prom_mode_e    mode;
  prom_mode_e    mode_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] din_q;
  logic [DW-1:0] rd_q;
  logic          sweep_busy;
  logic [AW-1:0] sweep_addr;

  logic          we;
  logic [AW-1:0] waddr;
  logic [DW-1:0] wdata;
  logic          lw_en;
  logic [AW-1:0] lw_addr;
  logic [DW-1:0] lw_data;
  logic [DW-1:0] cur_word;

  prom_mode_dec u_dec (
    .ce_n   (ce_n),
    .oe_n   (oe_n),
    .vpp_hi (vpp_hi),
    .a9_hv  (a9_hv),
    .mode   (mode)
  );

  prom_eraser #(
    .DEPTH    (DEPTH),
    .ERASABLE (ERASABLE)
  ) u_erase (
    .clk   (clk),
    .rst   (rst),
    .start (bulk_erase),
    .busy  (sweep_busy),
    .addr  (sweep_addr)
  );

  prom_array #(
    .DEPTH (DEPTH),
    .DW    (DW)
  ) u_mem (
    .clk   (clk),
    .we    (we),
    .waddr (waddr),
    .wdata (wdata),
    .raddr (addr),
    .rdata (rd_q)
  );

  // Stage 1: capture the operation; a running sweep turns it into standby.
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MD_STANDBY;
      addr_q <= '0;
      din_q  <= '0;
    end else begin
      mode_q <= sweep_busy ? MD_STANDBY : mode;
      addr_q <= addr;
      din_q  <= data_in;
    end
  end

  // The read port misses only the write of the edge that sampled it.
  assign cur_word = (lw_en && (lw_addr == addr_q)) ? lw_data : rd_q;

  always_comb begin
    if (sweep_busy) begin
      we    = 1'b1;
      waddr = sweep_addr;
      wdata = '1;
    end else if (mode_q == MD_PROGRAM) begin
      we    = 1'b1;
      waddr = addr_q;
      wdata = cur_word & din_q;
    end else begin
      we    = 1'b0;
      waddr = addr_q;
      wdata = cur_word;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lw_en   <= 1'b0;
      lw_addr <= '0;
      lw_data <= '0;
    end else begin
      lw_en   <= we;
      lw_addr <= waddr;
      lw_data <= wdata;
    end
  end

  // Stage 2: registered bus.
  always_ff @(posedge clk) begin
    if (rst) begin
      data_oe  <= 1'b0;
      data_out <= '0;
    end else begin
      unique case (mode_q)
        MD_READ: begin
          data_oe  <= 1'b1;
          data_out <= cur_word;
        end
        MD_SIGNATURE: begin
          data_oe  <= 1'b1;
          data_out <= addr_q[0] ? DEV_ID : MFG_ID;
        end
        default: begin
          data_oe  <= 1'b0;
          data_out <= '0;
        end
      endcase
    end
  end

endmodule

// File: rtl/prom_core_chk.sv
module prom_core_chk #(
  parameter int            DW     = 8,
  parameter logic [DW-1:0] MFG_ID = 8'h97,
  parameter logic [DW-1:0] DEV_ID = 8'h85
) (
  input logic          clk,
  input logic          rst,
  input logic          ce_n,
  input logic          oe_n,
  input logic          vpp_hi,
  input logic          a9_hv,
  input logic          addr0,
  input logic [DW-1:0] data_out,
  input logic          data_oe
);

  logic [1:0] vld;
  logic ce1, oe1, vp1, hv1, a01;
  logic ce2, oe2, vp2, hv2, a02;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= 2'd0;
    end else if (vld != 2'd2) begin
      vld <= vld + 2'd1;
    end
    ce1 <= ce_n;  oe1 <= oe_n;  vp1 <= vpp_hi; hv1 <= a9_hv; a01 <= addr0;
    ce2 <= ce1;   oe2 <= oe1;   vp2 <= vp1;    hv2 <= hv1;   a02 <= a01;
  end

  logic full;
  assign full = (vld == 2'd2);

  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> !data_oe); // R1

  AST_DRIVE_ONLY_READ: assert property (@(posedge clk) disable iff (rst)
    (full && data_oe) |-> (!ce2 && !oe2 && !vp2)); // R2

  AST_DISABLE_HIZ: assert property (@(posedge clk) disable iff (rst)
    (full && !ce2 && !vp2 && oe2) |-> !data_oe); // R3

  AST_STANDBY_HIZ: assert property (@(posedge clk) disable iff (rst)
    (full && ce2 && !vp2) |-> !data_oe); // R4

  AST_PROGRAM_HIZ: assert property (@(posedge clk) disable iff (rst)
    (full && !ce2 && vp2) |-> !data_oe); // R5

  AST_INHIBIT_HIZ: assert property (@(posedge clk) disable iff (rst)
    (full && ce2 && vp2) |-> !data_oe); // R6

  AST_SIG_MFG: assert property (@(posedge clk) disable iff (rst)
    (full && data_oe && hv2 && !a02) |-> (data_out == MFG_ID)); // R7

  AST_SIG_DEV: assert property (@(posedge clk) disable iff (rst)
    (full && data_oe && hv2 && a02) |-> (data_out == DEV_ID)); // R7

endmodule

bind prom_core prom_core_chk #(
  .DW     (DW),
  .MFG_ID (MFG_ID),
  .DEV_ID (DEV_ID)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ce_n     (ce_n),
  .oe_n     (oe_n),
  .vpp_hi   (vpp_hi),
  .a9_hv    (a9_hv),
  .addr0    (addr[0]),
  .data_out (data_out),
  .data_oe  (data_oe)
);

// File: tb/prom_core_test.sv
`timescale 1ns/1ps
module prom_core_test;

  localparam int DEPTH = 64;
  localparam int AW    = $clog2(DEPTH);
  localparam int DW    = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ce_n = 1'b1, oe_n = 1'b1, vpp_hi = 1'b0, a9_hv = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] data_in = '0;
  logic          bulk_erase = 1'b0;
  logic [DW-1:0] data_out;
  logic          data_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  prom_core #(.DEPTH(DEPTH), .DW(DW), .ERASABLE(1'b1)) uut (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .vpp_hi(vpp_hi),
    .a9_hv(a9_hv), .addr(addr), .data_in(data_in), .bulk_erase(bulk_erase),
    .data_out(data_out), .data_oe(data_oe)
  );

  logic [DW-1:0] model [DEPTH];

  // Two-deep queue of pending expectations.
  bit            p_vld [2];
  bit            p_oe  [2];
  logic [DW-1:0] p_dat [2];
  string         p_tag [2];

  function automatic string mode_tag(logic c, logic o, logic v, logic h);
    if (c) return v ? "R6" : "R4";
    if (v) return "R5";
    if (o) return "R3";
    if (h) return "R7";
    return "R2";
  endfunction

  task automatic check_oldest();
    if (!p_vld[1]) return;
    checks++;
    if (data_oe !== p_oe[1]) begin
      errors++;
      $display("FAIL %s data_oe actual=%0b expected=%0b", p_tag[1], data_oe, p_oe[1]);
    end else if (p_oe[1] && data_out !== p_dat[1]) begin
      errors++;
      $display("FAIL %s data_out actual=%02h expected=%02h", p_tag[1], data_out, p_dat[1]);
    end
  endtask

  // One operation per cycle; hold=1 means a sweep is running (R10).
  task automatic step(input logic c, input logic o, input logic v, input logic h,
                      input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input logic er, input bit hold, input string tag);
    bit            e_oe;
    logic [DW-1:0] e_d;
    string         t;
    @(negedge clk);
    check_oldest();
    e_oe = 1'b0;
    e_d  = '0;
    t = (tag != "") ? tag : mode_tag(c, o, v, h);
    if (!hold) begin
      if (!c && v) begin
        model[a] = model[a] & d;
      end else if (!c && !o && h) begin
        e_oe = 1'b1;
        e_d  = a[0] ? 8'h85 : 8'h97;
      end else if (!c && !o) begin
        e_oe = 1'b1;
        e_d  = model[a];
      end
    end
    p_vld[1] = p_vld[0]; p_oe[1] = p_oe[0]; p_dat[1] = p_dat[0]; p_tag[1] = p_tag[0];
    p_vld[0] = 1'b1;     p_oe[0] = e_oe;    p_dat[0] = e_d;      p_tag[0] = t;
    ce_n = c; oe_n = o; vpp_hi = v; a9_hv = h; addr = a; data_in = d; bulk_erase = er;
  endtask

  task automatic rd(input logic [AW-1:0] a, input string tag);
    step(1'b0, 1'b0, 1'b0, 1'b0, a, 8'h00, 1'b0, 1'b0, tag);
  endtask

  task automatic pg(input logic [AW-1:0] a, input logic [DW-1:0] d);
    step(1'b0, 1'b0, 1'b1, 1'b0, a, d, 1'b0, 1'b0, "R5");
  endtask

  task automatic rand_ops(input int n);
    for (int i = 0; i < n; i++) begin
      int sel;
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      sel = $urandom_range(0, 99);
      a   = AW'($urandom_range(0, DEPTH - 1));
      d   = DW'($urandom | $urandom);
      if (sel < 20)      step(1'b0, 1'(($urandom)), 1'b1, 1'($urandom), a, d, 1'b0, 1'b0, "");
      else if (sel < 30) step(1'b1, 1'($urandom), 1'b1, 1'($urandom), a, 8'h00, 1'b0, 1'b0, "");
      else if (sel < 40) step(1'b1, 1'($urandom), 1'b0, 1'($urandom), a, d, 1'b0, 1'b0, "");
      else if (sel < 50) step(1'b0, 1'b1, 1'b0, 1'($urandom), a, d, 1'b0, 1'b0, "");
      else if (sel < 60) step(1'b0, 1'b0, 1'b0, 1'b1, a, d, 1'b0, 1'b0, "");
      else               rd(a, "");
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < DEPTH; i++) model[i] = '1;
    p_vld[0] = 1'b0; p_vld[1] = 1'b0;

    repeat (3) @(negedge clk);
    checks++;
    if (data_oe !== 1'b0) begin
      errors++;
      $display("FAIL R1 data_oe actual=%0b expected=0", data_oe);
    end
    rst = 1'b0;

    // R8: blank array
    rd(0, "R8"); rd(1, "R8"); rd(AW'(DEPTH - 1), "R8"); rd(37, "R8");

    // R9: accumulation, back-to-back, then read at once
    pg(5, 8'hF0); pg(5, 8'h3C); rd(5, "R9");
    pg(5, 8'hFF); rd(5, "R9");
    pg(6, 8'h0F); pg(6, 8'hFF); pg(6, 8'hF3); rd(6, "R9"); rd(6, "R9");

    // R6: inhibit leaves word blank
    step(1'b1, 1'b0, 1'b1, 1'b0, 7, 8'h00, 1'b0, 1'b0, "R6"); rd(7, "R6");
    // R5: oe_n and a9_hv have no say while programming
    step(1'b0, 1'b1, 1'b1, 1'b1, 9, 8'h5A, 1'b0, 1'b0, "R5"); rd(9, "R5");
    // R4: standby with output enable low and high voltage set
    step(1'b1, 1'b0, 1'b0, 1'b1, 9, 8'h00, 1'b0, 1'b0, "R4");
    // R3: disable, then the word is unchanged
    step(1'b0, 1'b1, 1'b0, 1'b0, 9, 8'h00, 1'b0, 1'b0, "R3"); rd(9, "R3");
    // R7: both identifiers, address bits above bit 0 not zero
    step(1'b0, 1'b0, 1'b0, 1'b1, 6'h12, 8'h00, 1'b0, 1'b0, "R7");
    step(1'b0, 1'b0, 1'b0, 1'b1, 6'h13, 8'h00, 1'b0, 1'b0, "R7");

    rand_ops(3000);

    // R10: erase sweep; every slot gets a program or a read that must do nothing
    step(1'b1, 1'b1, 1'b0, 1'b0, 0, 8'h00, 1'b1, 1'b0, "R10");
    for (int i = 0; i < DEPTH; i++) begin
      if (i % 2 == 0) step(1'b0, 1'b0, 1'b1, 1'b0, AW'(i), 8'h00, 1'b0, 1'b1, "R10");
      else            step(1'b0, 1'b0, 1'b0, 1'b0, AW'(i), 8'h00, 1'b0, 1'b1, "R10");
    end
    for (int i = 0; i < DEPTH; i++) model[i] = '1;
    for (int i = 0; i < DEPTH; i++) rd(AW'(i), "R10");

    rand_ops(500);

    repeat (3) step(1'b1, 1'b1, 1'b0, 1'b0, 0, 8'h00, 1'b0, 1'b0, "R4");
    done = 1'b1;
    summary();
    $finish;
  end

endmodule